// File: doc/BRIEF.md
# PLL Synthesizer Control and Lock-Loss Sequencer

This block holds the software-visible settings of a frequency synthesizer's feedback path: a 5-bit multiplication factor, a 3-bit power-of-two output divider, a loss-of-clock enable, and two enables that decide what happens when lock is lost. A small lock-acquisition counter stands in for the analog loop. Lock is reported a fixed number of reference clock cycles after the last change of the multiplication factor. The analog loop, the modulation engine and the loss-of-clock detector are outside the block. It only drives their restart and enable controls.

When software rewrites the multiplication factor, the sequencer leaves its locked state at once. It can then issue a calibration-restart pulse, a one-cycle reset request and a sticky interrupt flag, each according to its own enable. Two mode inputs override the programmed settings. Dual-controller mode fixes the factor at 2. Bypass mode ignores the multiplication field, the divider and the loss-of-clock enable.

The sequencer has three states:
- `ST_ACQUIRE` counts toward lock.
- `ST_LOCKED` reports lock.
- `ST_LOST` is a single cycle entered when lock drops.

Its transitions are:
- ACQUIRE to LOCKED when the counter reaches its end.
- ACQUIRE to ACQUIRE with the counter cleared when the factor changes.
- LOCKED to LOST when the factor changes.
- LOST to ACQUIRE always, with the counter cleared again if the factor changes in that cycle.

Top module: `pllsyn_ctl`

## Requirements
- R1: The control register at address 0 reads back as mult in bits 4:0, odiv in bits 7:5, loss-of-clock enable in bit 8, reset enable in bit 10 and interrupt enable in bit 11. Reset values are mult=8 and 0 for every other field.
- R2: Bit 9 of the control register, and every bit above bit 11, reads 0 whatever value was written.
- R3: In normal mode, a write to address 0 whose mult differs from the stored value makes `lock` 0 in the next cycle. `lock` returns to 1 exactly LOCK_CYCLES clock edges after that write edge. A write with the same mult, or one that changes only other fields, leaves `lock` at 1.
- R4: After reset is released, `lock` goes to 1 on clock edge LOCK_CYCLES and is 0 before that edge.
- R5: `cal_restart` is a one-cycle pulse that coincides with the lock drop. It is issued only when `mod_en` is 1 at the time of the mult-changing write.
- R6: `lol_reset_req` is a one-cycle pulse issued only when a mult change takes the sequencer out of the locked state while the stored reset enable (the value held before that write) is 1. A mult change during acquisition gives no pulse.
- R7: A lock loss taken while the interrupt enable is 1 sets a sticky flag. The flag shows on `lol_irq` and in bit 1 of the status register at address 1. Writing 1 to status bit 1 clears it, and writing 0 there leaves it unchanged. Status bit 0 reads `lock`.
- R8: With `dual_mode`=1 and `bypass_mode`=0, `eff_mult` is 2 and a mult write does not drop lock.
- R9: With `bypass_mode`=1, `eff_mult` is 1, `out_div` is 1 and `loc_clk_en` is 0, and a mult write does not drop lock. Bypass takes priority over dual mode.
- R10: In normal mode, `eff_mult` equals mult and `out_div` equals 2^odiv.
- R11: Outside bypass, `loc_clk_en` follows the loss-of-clock enable. That enable never drops lock and never produces a reset or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control, 1 = status |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data for `addr` |
| mod_en | input | 1 | Frequency modulation enabled |
| dual_mode | input | 1 | Dual-controller mode |
| bypass_mode | input | 1 | Bypass mode |
| lock | output | 1 | Lock indication |
| cal_restart | output | 1 | Calibration-restart pulse |
| lol_reset_req | output | 1 | Loss-of-lock reset request pulse |
| lol_irq | output | 1 | Sticky loss-of-lock interrupt |
| eff_mult | output | 5 | Effective multiplication factor |
| out_div | output | 8 | Effective output divide ratio |
| loc_clk_en | output | 1 | Effective loss-of-clock enable |

## Verification
The hardest situation to reach is a lock loss with a particular enable pattern. The sequencer must first sit in its locked state, and the enables must already be stored before the factor is rewritten. For each of the eight combinations of modulation, reset enable and interrupt enable, the bench first writes the enables with the current factor unchanged, so lock is not disturbed. It then rewrites only the factor and checks the pulses in the cycle after the write edge, and checks lock at edges LOCK_CYCLES-1 and LOCK_CYCLES. A second change issued during acquisition and a write that clears the reset enable together with the factor change cover the remaining orderings.

// File: rtl/pllsyn_pkg.sv
package pllsyn_pkg;

    localparam int MF_W      = 5;
    localparam int OD_W      = 3;
    localparam int ODV_W     = 1 << OD_W;

    localparam int MF_LSB    = 0;
    localparam int OD_LSB    = 5;
    localparam int LOC_BIT   = 8;
    localparam int RSV_BIT   = 9;
    localparam int RST_BIT   = 10;
    localparam int IRQ_BIT   = 11;
    localparam int CTRL_BITS = 12;

    localparam int STS_LOCK_BIT = 0;
    localparam int STS_IRQ_BIT  = 1;

    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_LOST    = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic            irq_en;
        logic            rst_en;
        logic            loc_en;
        logic [OD_W-1:0] odiv;
        logic [MF_W-1:0] mfac;
    } ctrl_t;

endpackage

// File: rtl/pllsyn_regs.sv
module pllsyn_regs
    import pllsyn_pkg::*;
#(
    parameter int DW       = 16,
    parameter int RESET_MF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic          lock,
    input  logic          lol_flag,
    output ctrl_t         ctrl,
    output logic          mf_wr_chg,
    output logic          irq_clr,
    output logic [DW-1:0] rd_data
);

    localparam logic [MF_W-1:0] MF_INIT = MF_W'(RESET_MF);

    logic wr_ctrl;
    logic wr_stat;

    assign wr_ctrl   = wr_en && (addr == 1'b0);
    assign wr_stat   = wr_en && (addr == 1'b1);
    assign mf_wr_chg = wr_ctrl && (wdata[MF_LSB +: MF_W] != ctrl.mfac);
    assign irq_clr   = wr_stat && wdata[STS_IRQ_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl.mfac   <= MF_INIT;
            ctrl.odiv   <= '0;
            ctrl.loc_en <= 1'b0;
            ctrl.rst_en <= 1'b0;
            ctrl.irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl.mfac   <= wdata[MF_LSB +: MF_W];
            ctrl.odiv   <= wdata[OD_LSB +: OD_W];
            ctrl.loc_en <= wdata[LOC_BIT];
            ctrl.rst_en <= wdata[RST_BIT];
            ctrl.irq_en <= wdata[IRQ_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == 1'b0) begin
            rd_data[MF_LSB +: MF_W] = ctrl.mfac;
            rd_data[OD_LSB +: OD_W] = ctrl.odiv;
            rd_data[LOC_BIT]        = ctrl.loc_en;
            rd_data[RST_BIT]        = ctrl.rst_en;
            rd_data[IRQ_BIT]        = ctrl.irq_en;
        end else begin
            rd_data[STS_LOCK_BIT]   = lock;
            rd_data[STS_IRQ_BIT]    = lol_flag;
        end
    end

endmodule

// File: rtl/pllsyn_seq.sv
module pllsyn_seq
    import pllsyn_pkg::*;
#(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mf_change,
    input  logic mod_en,
    input  logic rst_en,
    input  logic irq_en,
    input  logic irq_clr,
    output logic lock,
    output logic cal_restart,
    output logic lol_reset_req,
    output logic lol_flag
);

    localparam int          CW   = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    seq_st_e         state, state_nx;
    logic [CW-1:0]   cnt, cnt_nx;
    logic            lose;

    assign lose = (state == ST_LOCKED) && mf_change;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_ACQUIRE: begin
                if (mf_change) begin
                    cnt_nx = '0;
                end else if (cnt == LAST) begin
                    state_nx = ST_LOCKED;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            ST_LOCKED: begin
                if (mf_change) begin
                    state_nx = ST_LOST;
                    cnt_nx   = '0;
                end
            end
            ST_LOST: begin
                state_nx = ST_ACQUIRE;
                cnt_nx   = mf_change ? '0 : cnt + CW'(1);
            end
            default: begin
                state_nx = ST_ACQUIRE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACQUIRE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock          <= 1'b0;
            cal_restart   <= 1'b0;
            lol_reset_req <= 1'b0;
            lol_flag      <= 1'b0;
        end else begin
            lock          <= (state_nx == ST_LOCKED);
            cal_restart   <= mf_change && mod_en;
            lol_reset_req <= lose && rst_en;
            if (lose && irq_en)
                lol_flag <= 1'b1;
            else if (irq_clr)
                lol_flag <= 1'b0;
        end
    end

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mf_change |=> !lock); // R3
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !mf_change) |=> lock); // R3
    AST_CAL_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_restart |-> !lock); // R5
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lol_reset_req |=> !lol_reset_req); // R6
    AST_RST_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        lol_reset_req |-> (!lock && $past(lock))); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_flag && !irq_clr) |=> lol_flag); // R7

endmodule

// File: rtl/pllsyn_eff.sv
module pllsyn_eff
    import pllsyn_pkg::*;
(
    input  logic             bypass_mode,
    input  logic             dual_mode,
    input  logic [MF_W-1:0]  mfac,
    input  logic [OD_W-1:0]  odiv,
    input  logic             loc_en,
    output logic [MF_W-1:0]  eff_mult,
    output logic [ODV_W-1:0] out_div,
    output logic             loc_clk_en
);

    logic [ODV_W-1:0] dec;

    for (genvar g = 0; g < ODV_W; g++) begin : g_dec
        assign dec[g] = (odiv == OD_W'(g));
    end

    always_comb begin
        if (bypass_mode)
            eff_mult = MF_W'(1);
        else if (dual_mode)
            eff_mult = MF_W'(2);
        else
            eff_mult = mfac;
    end

    assign out_div    = bypass_mode ? ODV_W'(1) : dec;
    assign loc_clk_en = loc_en && !bypass_mode;

endmodule

// File: rtl/pllsyn_ctl.sv
module pllsyn_ctl
    import pllsyn_pkg::*;
#(
    parameter int DW          = 16,
    parameter int LOCK_CYCLES = 64,
    parameter int RESET_MF    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data,
    input  logic             mod_en,
    input  logic             dual_mode,
    input  logic             bypass_mode,
    output logic             lock,
    output logic             cal_restart,
    output logic             lol_reset_req,
    output logic             lol_irq,
    output logic [MF_W-1:0]  eff_mult,
    output logic [ODV_W-1:0] out_div,
    output logic             loc_clk_en
);

    ctrl_t ctrl;
    logic  mf_wr_chg;
    logic  mf_change;
    logic  irq_clr;
    logic  lol_flag;

    pllsyn_regs #(.DW(DW), .RESET_MF(RESET_MF)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .lock      (lock),
        .lol_flag  (lol_flag),
        .ctrl      (ctrl),
        .mf_wr_chg (mf_wr_chg),
        .irq_clr   (irq_clr),
        .rd_data   (rd_data)
    );

    assign mf_change = mf_wr_chg && !bypass_mode && !dual_mode;

    pllsyn_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mf_change     (mf_change),
        .mod_en        (mod_en),
        .rst_en        (ctrl.rst_en),
        .irq_en        (ctrl.irq_en),
        .irq_clr       (irq_clr),
        .lock          (lock),
        .cal_restart   (cal_restart),
        .lol_reset_req (lol_reset_req),
        .lol_flag      (lol_flag)
    );

    pllsyn_eff u_eff (
        .bypass_mode (bypass_mode),
        .dual_mode   (dual_mode),
        .mfac        (ctrl.mfac),
        .odiv        (ctrl.odiv),
        .loc_en      (ctrl.loc_en),
        .eff_mult    (eff_mult),
        .out_div     (out_div),
        .loc_clk_en  (loc_clk_en)
    );

    assign lol_irq = lol_flag;

    AST_LOC_NO_LOCK_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !mf_wr_chg) |=> (lock && !lol_reset_req)); // R11
    AST_MODE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && (bypass_mode || dual_mode)) |=> lock); // R8

endmodule

// File: tb/pllsyn_ctl_test.sv
module pllsyn_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 8;
    localparam int DW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          addr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          mod_en = 1'b0;
    logic          dual_mode = 1'b0;
    logic          bypass_mode = 1'b0;
    logic          lock, cal_restart, lol_reset_req, lol_irq, loc_clk_en;
    logic [4:0]    eff_mult;
    logic [7:0]    out_div;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int cur_mf = 8;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllsyn_ctl #(.DW(DW), .LOCK_CYCLES(L), .RESET_MF(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .mod_en(mod_en), .dual_mode(dual_mode),
        .bypass_mode(bypass_mode), .lock(lock), .cal_restart(cal_restart),
        .lol_reset_req(lol_reset_req), .lol_irq(lol_irq), .eff_mult(eff_mult),
        .out_div(out_div), .loc_clk_en(loc_clk_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    function automatic logic [DW-1:0] ctl_word(input int mf, input int od, input bit loc,
                                               input bit rsten, input bit irqen);
        logic [DW-1:0] w;
        w = '0;
        w[4:0] = mf[4:0];
        w[7:5] = od[2:0];
        w[8]   = loc;
        w[10]  = rsten;
        w[11]  = irqen;
        return w;
    endfunction

    task automatic write(input bit a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    task automatic read(input bit a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rd_data;
        addr = 1'b0;
    endtask

    task automatic wait_lock();
        repeat (L + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        int nm;

        // Reset and initial lock timing
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read(1'b0, rd);
        chk_eq("R1", "reset ctrl value", int'(rd), 8);
        chk_eq("R4", "lock at reset", int'(lock), 0);
        repeat (L - 1) @(negedge clk);
        chk_eq("R4", "lock before edge L", int'(lock), 0);
        @(negedge clk);
        chk_eq("R4", "lock at edge L", int'(lock), 1);
        read(1'b1, rd);
        chk_eq("R7", "status lock bit", int'(rd[0]), 1);

        // Lock-loss sequences for every enable combination
        for (int c = 0; c < 8; c++) begin
            bit m, re, ie;
            m = c[0]; re = c[1]; ie = c[2];
            write(1'b0, ctl_word(cur_mf, 0, 1'b0, re, ie));
            chk_eq("R3", "enables-only write keeps lock", int'(lock), 1);
            write(1'b1, 16'h0002);
            mod_en = m;
            nm = (cur_mf + 5) % 32;
            write(1'b0, ctl_word(nm, 0, 1'b0, re, ie));
            cur_mf = nm;
            chk_eq("R3", "lock drops after mult change", int'(lock), 0);
            chk_eq("R5", "cal_restart pulse", int'(cal_restart), int'(m));
            chk_eq("R6", "reset request pulse", int'(lol_reset_req), int'(re));
            chk_eq("R7", "irq flag set", int'(lol_irq), int'(ie));
            @(negedge clk);
            chk_eq("R5", "cal_restart single cycle", int'(cal_restart), 0);
            chk_eq("R6", "reset request single cycle", int'(lol_reset_req), 0);
            chk_eq("R7", "irq flag sticky", int'(lol_irq), int'(ie));
            repeat (L - 2) @(negedge clk);
            chk_eq("R3", "lock still low at edge L-1", int'(lock), 0);
            @(negedge clk);
            chk_eq("R3", "lock back at edge L", int'(lock), 1);
            mod_en = 1'b0;
        end

        // Flag clear: writing 0 has no effect, writing 1 clears
        write(1'b1, 16'h0000);
        chk_eq("R7", "write 0 leaves flag", int'(lol_irq), 1);
        write(1'b1, 16'h0002);
        chk_eq("R7", "write 1 clears flag", int'(lol_irq), 0);
        read(1'b1, rd);
        chk_eq("R7", "status irq bit cleared", int'(rd[1]), 0);

        // Stored reset enable governs; clearing it in the same write does not help
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b1, 1'b0));
        nm = (cur_mf + 1) % 32;
        write(1'b0, ctl_word(nm, 0, 1'b0, 1'b0, 1'b0));
        cur_mf = nm;
        chk_eq("R6", "stored enable gives pulse", int'(lol_reset_req), 1);
        // Change during acquisition: no reset pulse, count restarts
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b1, 1'b1));
        nm = (cur_mf + 3) % 32;
        write(1'b0, ctl_word(nm, 0, 1'b0, 1'b1, 1'b1));
        cur_mf = nm;
        chk_eq("R6", "no pulse during acquisition", int'(lol_reset_req), 0);
        chk_eq("R7", "no flag during acquisition", int'(lol_irq), 0);
        repeat (L - 1) @(negedge clk);
        chk_eq("R3", "restarted count, lock low", int'(lock), 0);
        @(negedge clk);
        chk_eq("R3", "restarted count, lock high", int'(lock), 1);
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b0, 1'b0));

        // Same value and divider-only writes keep lock
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b0, 1'b0));
        chk_eq("R3", "same mult keeps lock", int'(lock), 1);
        write(1'b0, ctl_word(cur_mf, 6, 1'b0, 1'b0, 1'b0));
        chk_eq("R3", "divider write keeps lock", int'(lock), 1);

        // Loss-of-clock enable: visible, no lock effect
        write(1'b0, ctl_word(cur_mf, 0, 1'b1, 1'b1, 1'b1));
        chk_eq("R11", "loc_clk_en follows enable", int'(loc_clk_en), 1);
        chk_eq("R11", "loc enable keeps lock", int'(lock), 1);
        chk_eq("R11", "loc enable no reset", int'(lol_reset_req), 0);
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b1, 1'b1));
        chk_eq("R11", "loc_clk_en off", int'(loc_clk_en), 0);
        chk_eq("R11", "loc disable no irq", int'(lol_irq), 0);

        // Dual and bypass: mult writes do not drop lock
        write(1'b0, ctl_word(cur_mf, 0, 1'b1, 1'b1, 1'b1));
        dual_mode = 1'b1;
        nm = (cur_mf + 7) % 32;
        write(1'b0, ctl_word(nm, 0, 1'b1, 1'b1, 1'b1));
        cur_mf = nm;
        chk_eq("R8", "dual mode keeps lock", int'(lock), 1);
        chk_eq("R8", "dual mode no reset", int'(lol_reset_req), 0);
        dual_mode = 1'b0;
        bypass_mode = 1'b1;
        #1;
        chk_eq("R9", "bypass loc_clk_en", int'(loc_clk_en), 0);
        nm = (cur_mf + 7) % 32;
        write(1'b0, ctl_word(nm, 0, 1'b1, 1'b1, 1'b1));
        cur_mf = nm;
        chk_eq("R9", "bypass keeps lock", int'(lock), 1);
        chk_eq("R9", "bypass no irq", int'(lol_irq), 0);
        bypass_mode = 1'b0;
        write(1'b0, ctl_word(cur_mf, 0, 1'b0, 1'b0, 1'b0));

        // Reserved bits
        write(1'b0, 16'hFFFF);
        cur_mf = 31;
        read(1'b0, rd);
        chk_eq("R2", "reserved bits read zero", int'(rd), 16'h0DFF);
        chk_eq("R1", "mult field readback", int'(rd[4:0]), 31);

        // Multiplication factor sweep over all modes
        for (int v = 0; v < 32; v++) begin
            write(1'b0, ctl_word(v, 0, 1'b0, 1'b0, 1'b0));
            read(1'b0, rd);
            chk_eq("R1", "mult readback", int'(rd[4:0]), v);
            chk_eq("R10", "eff_mult normal", int'(eff_mult), v);
            dual_mode = 1'b1; #1;
            chk_eq("R8", "eff_mult dual", int'(eff_mult), 2);
            bypass_mode = 1'b1; #1;
            chk_eq("R9", "eff_mult bypass over dual", int'(eff_mult), 1);
            dual_mode = 1'b0; #1;
            chk_eq("R9", "eff_mult bypass", int'(eff_mult), 1);
            bypass_mode = 1'b0;
        end

        // Output divider sweep
        for (int o = 0; o < 8; o++) begin
            write(1'b0, ctl_word(5, o, 1'b0, 1'b0, 1'b0));
            read(1'b0, rd);
            chk_eq("R1", "odiv readback", int'(rd[7:5]), o);
            chk_eq("R10", "out_div normal", int'(out_div), 1 << o);
            bypass_mode = 1'b1; #1;
            chk_eq("R9", "out_div bypass", int'(out_div), 1);
            bypass_mode = 1'b0;
        end

        finish_run();
    end

endmodule